// File: doc/BRIEF.md
# Bit-Field Register Write Sequencer

This block replays a stored list of register updates into a control register file without help from the host once a run has begun. Each step names a target register, a bit field inside it (lowest bit and width), the value for that field, a delay code and a last-step marker. For every step the engine reads the target register, replaces only the chosen field, writes the result back, and then waits out the step's delay before moving to the next entry. A run ends once the step carrying the last-step marker has finished its delay.

The host fills the 32-entry step store through three write strobes. One sets a pointer to an entry. The second loads the placement half of that entry (address, lowest bit, width code). The third loads the action half (data, delay code, last-step marker). The host starts a run by giving an entry number, and can cut a run short with an abort pulse or by clearing the enable. After reset the store already holds a short power-up list starting at entry 0 and a power-down list starting at entry 16. A delay unit is one timebase tick, which is `TICK_CYCLES` clocks and stands for 62.5 µs in the target system.

Top module: `fieldwr_seq`

## Requirements
- R1: After reset `busy`, `rf_re` and `rf_we` are low, and the store holds defaults. Entry 0: addr 0x01, low bit 0, width code 2, data 0x05, delay 0. Entry 1: addr 0x02, low bit 4, code 3, data 0x0A, delay 1. Entry 2: addr 0x03, low bit 8, code 7, data 0x3C, delay 0, last. Entry 16: addr 0x02, low bit 4, code 3, data 0x00, delay 0. Entry 17: addr 0x01, low bit 0, code 2, data 0x00, delay 0, last. All other entries are zero.
- R2: A pulse on `ptr_we` loads the entry pointer from `ptr_idx`. `place_we` then copies `place_addr`, `place_lsb` and `place_wcode` into the pointed entry, and `act_we` copies `act_data`, `act_delay` and `act_last` into it.
- R3: A step writes back the old register value with bits lsb..lsb+code replaced by the low code+1 bits of the data (field width = code+1, 1 to 8). Data bits above the field width are ignored, and register bits outside the field keep their old value.
- R4: With `en` high, `busy` low and `abort` low, a `go_we` pulse starts the run at `go_idx` on the next clock: `busy` rises and the first read is issued. Entries run in increasing order until the step with its last-step bit set has completed.
- R5: Each step occupies exactly `TICK_CYCLES`*(2^delay+8) clocks, counted from its read cycle to the next step's read cycle. The read and write cycles are included. After the last step, `busy` falls at the end of that step's time.
- R6: `abort` while busy stops the run: `busy` is low on the next clock and no further write occurs.
- R7: While `en` is low no run starts. Dropping `en` during a run stops it like an abort.
- R8: A `go_we` pulse while busy is ignored; the running list continues unchanged.
- R9: The entry after index 31 is index 0.
- R10: Field bits that would land above register bit 15 are discarded.
- R11: Each step issues one read (`rf_re`) followed on the next clock by one write (`rf_we`) to the same address. The read data is expected on `rf_rdata` in the cycle after `rf_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable |
| ptr_we | input | 1 | Load entry pointer |
| ptr_idx | input | 5 | New entry pointer value |
| place_we | input | 1 | Write placement half of pointed entry |
| place_addr | input | 8 | Target register address |
| place_lsb | input | 4 | Lowest bit of the field |
| place_wcode | input | 3 | Field width minus one |
| act_we | input | 1 | Write action half of pointed entry |
| act_data | input | 8 | Field value |
| act_delay | input | 4 | Delay code (step = 2^code+8 ticks) |
| act_last | input | 1 | Last step of a list |
| go_we | input | 1 | Start request |
| go_idx | input | 5 | First entry of the run |
| abort | input | 1 | Stop the current run |
| rf_re | output | 1 | Register file read strobe |
| rf_addr | output | 8 | Register file address |
| rf_rdata | input | 16 | Read data, valid the cycle after rf_re |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 16 | Merged write data |
| busy | output | 1 | A run is in progress |

## Verification
The bench targets the field edges. It uses a full-width field at the top of the register, where a bad merge would wrap bits into the low end or corrupt bit 15. It also uses a narrow field with extra high data bits, where a missing width mask would clobber neighbouring bits. Step spacing is measured on every write and on the total busy time, so an off-by-one in the tick counter or a delay that leaves out the read and write cycles shows as a wrong interval. Runs that cross entry 31, aborts after the first write, enable loss, and start requests made while busy each expose an engine that writes past a stop, fails to wrap, or restarts at the new index.

// File: rtl/fieldwr_pkg.sv
package fieldwr_pkg;
  localparam int ADDR_W  = 8;
  localparam int LSB_W   = 4;
  localparam int WCODE_W = 3;
  localparam int DATA_W  = 8;
  localparam int DLY_W   = 4;
  localparam int REG_W   = 16;
  localparam int DSEL_W  = $clog2(DATA_W);

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [LSB_W-1:0]   lsb;
    logic [WCODE_W-1:0] wcode;
    logic [DATA_W-1:0]  data;
    logic [DLY_W-1:0]   dly;
    logic               last;
  } step_t;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_WAIT} st_e;

  // replace bits lsb..lsb+wcode of old with low data bits; bits beyond REG_W fall off
  function automatic logic [REG_W-1:0] field_merge(
    input logic [REG_W-1:0]   old,
    input logic [LSB_W-1:0]   lsb,
    input logic [WCODE_W-1:0] wcode,
    input logic [DATA_W-1:0]  data);
    logic [REG_W-1:0]  r;
    logic [DSEL_W-1:0] os;
    int lo, hi;
    r  = old;
    lo = int'(lsb);
    hi = lo + int'(wcode);
    for (int b = 0; b < REG_W; b++) begin
      if (b >= lo && b <= hi) begin
        os   = DSEL_W'(b - lo);
        r[b] = data[os];
      end
    end
    return r;
  endfunction

  // clocks per step for a delay code
  function automatic int unsigned step_cycles(input logic [DLY_W-1:0] d,
                                              input int unsigned tick);
    return tick * ((32'd1 << d) + 32'd8);
  endfunction

  function automatic step_t default_step(input int i);
    step_t s;
    s = '0;
    case (i)
      0:  s = '{addr: 8'h01, lsb: 4'd0, wcode: 3'd2, data: 8'h05, dly: 4'd0, last: 1'b0};
      1:  s = '{addr: 8'h02, lsb: 4'd4, wcode: 3'd3, data: 8'h0A, dly: 4'd1, last: 1'b0};
      2:  s = '{addr: 8'h03, lsb: 4'd8, wcode: 3'd7, data: 8'h3C, dly: 4'd0, last: 1'b1};
      16: s = '{addr: 8'h02, lsb: 4'd4, wcode: 3'd3, data: 8'h00, dly: 4'd0, last: 1'b0};
      17: s = '{addr: 8'h01, lsb: 4'd0, wcode: 3'd2, data: 8'h00, dly: 4'd0, last: 1'b1};
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fieldwr_store.sv
module fieldwr_store
  import fieldwr_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ptr_we,
  input  logic [IDX_W-1:0]   ptr_idx,
  input  logic               place_we,
  input  logic [ADDR_W-1:0]  place_addr,
  input  logic [LSB_W-1:0]   place_lsb,
  input  logic [WCODE_W-1:0] place_wcode,
  input  logic               act_we,
  input  logic [DATA_W-1:0]  act_data,
  input  logic [DLY_W-1:0]   act_delay,
  input  logic               act_last,
  input  logic [IDX_W-1:0]   rd_idx,
  output step_t              rd_step
);
  step_t            ents [DEPTH];
  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) ents[i] <= default_step(i);
    end else begin
      if (ptr_we) ptr <= ptr_idx;
      if (place_we) begin
        ents[ptr].addr  <= place_addr;
        ents[ptr].lsb   <= place_lsb;
        ents[ptr].wcode <= place_wcode;
      end
      if (act_we) begin
        ents[ptr].data <= act_data;
        ents[ptr].dly  <= act_delay;
        ents[ptr].last <= act_last;
      end
    end
  end

  assign rd_step = ents[rd_idx];
endmodule

// File: rtl/fieldwr_timer.sv
module fieldwr_timer
  import fieldwr_pkg::*;
#(
  parameter int TICK_CYCLES = 16,
  localparam int MAX_CYC = TICK_CYCLES * ((1 << ((1 << DLY_W) - 1)) + 8),
  localparam int CW = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [DLY_W-1:0] dly,
  output logic             expired
);
  logic [CW-1:0] cnt;
  // load happens in the read cycle, so the remaining count is the step length minus two
  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (load)       cnt <= CW'(step_cycles(dly, TICK_CYCLES) - 32'd2);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign expired = (cnt == '0);

  // R5
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> !expired);
endmodule

// File: rtl/fieldwr_ctrl.sv
module fieldwr_ctrl
  import fieldwr_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               go_we,
  input  logic [IDX_W-1:0]   go_idx,
  input  logic               abort,
  input  step_t              step,
  input  logic               expired,
  output logic [IDX_W-1:0]   cur,
  output logic               tmr_load,
  output logic               tmr_clear,
  output logic               rf_re,
  output logic [ADDR_W-1:0]  rf_addr,
  input  logic [REG_W-1:0]   rf_rdata,
  output logic               rf_we,
  output logic [REG_W-1:0]   rf_wdata,
  output logic               busy
);
  st_e                state;
  logic [ADDR_W-1:0]  h_addr;
  logic [LSB_W-1:0]   h_lsb;
  logic [WCODE_W-1:0] h_wcode;
  logic [DATA_W-1:0]  h_data;
  logic               h_last;

  // named events for the checks
  logic stop, launch, step_end;
  assign stop     = abort || !en;
  assign launch   = (state == S_IDLE) && go_we && en && !abort;
  assign step_end = (state == S_WAIT) && expired && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      h_addr  <= '0;
      h_lsb   <= '0;
      h_wcode <= '0;
      h_data  <= '0;
      h_last  <= 1'b0;
    end else if (state != S_IDLE && stop) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          cur   <= go_idx;
          state <= S_READ;
        end
        S_READ: begin
          h_addr  <= step.addr;
          h_lsb   <= step.lsb;
          h_wcode <= step.wcode;
          h_data  <= step.data;
          h_last  <= step.last;
          state   <= S_WRITE;
        end
        S_WRITE: state <= S_WAIT;
        S_WAIT: if (step_end) begin
          if (h_last) state <= S_IDLE;
          else begin
            cur   <= (cur == IDX_W'(DEPTH - 1)) ? '0 : cur + 1'b1;
            state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign tmr_load  = (state == S_READ);
  assign tmr_clear = stop;
  assign rf_re     = (state == S_READ);
  assign rf_addr   = (state == S_READ) ? step.addr : h_addr;
  assign rf_we     = (state == S_WRITE) && !stop;
  assign rf_wdata  = field_merge(rf_rdata, h_lsb, h_wcode, h_data);

  // R11
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(rf_re));
  // R11
  same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_addr == $past(rf_addr));
  // R6
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy);
  // R7
  en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  // R4
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && rf_re));
  // R5
  write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  // R8
  busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_we && state != S_WAIT) |=> $stable(cur));
endmodule

// File: rtl/fieldwr_seq.sv
module fieldwr_seq
  import fieldwr_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int TICK_CYCLES = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ptr_we,
  input  logic [IDX_W-1:0]   ptr_idx,
  input  logic               place_we,
  input  logic [ADDR_W-1:0]  place_addr,
  input  logic [LSB_W-1:0]   place_lsb,
  input  logic [WCODE_W-1:0] place_wcode,
  input  logic               act_we,
  input  logic [DATA_W-1:0]  act_data,
  input  logic [DLY_W-1:0]   act_delay,
  input  logic               act_last,
  input  logic               go_we,
  input  logic [IDX_W-1:0]   go_idx,
  input  logic               abort,
  output logic               rf_re,
  output logic [ADDR_W-1:0]  rf_addr,
  input  logic [REG_W-1:0]   rf_rdata,
  output logic               rf_we,
  output logic [REG_W-1:0]   rf_wdata,
  output logic               busy
);
  step_t            step;
  logic [IDX_W-1:0] cur;
  logic             expired, tmr_load, tmr_clear;

  fieldwr_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ptr_we(ptr_we), .ptr_idx(ptr_idx),
    .place_we(place_we), .place_addr(place_addr), .place_lsb(place_lsb),
    .place_wcode(place_wcode),
    .act_we(act_we), .act_data(act_data), .act_delay(act_delay), .act_last(act_last),
    .rd_idx(cur), .rd_step(step)
  );

  fieldwr_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .load(tmr_load),
    .dly(step.dly), .expired(expired)
  );

  fieldwr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .go_we(go_we), .go_idx(go_idx),
    .abort(abort), .step(step), .expired(expired), .cur(cur),
    .tmr_load(tmr_load), .tmr_clear(tmr_clear),
    .rf_re(rf_re), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .busy(busy)
  );
endmodule

// File: tb/sim_fieldwr_seq.sv
module sim_fieldwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 2;

  logic clk = 0, rst_n = 0, en = 0;
  logic ptr_we = 0, place_we = 0, act_we = 0, go_we = 0, abort = 0, act_last = 0;
  logic [4:0] ptr_idx = 0, go_idx = 0;
  logic [7:0] place_addr = 0, act_data = 0;
  logic [3:0] place_lsb = 0, act_delay = 0;
  logic [2:0] place_wcode = 0;
  logic rf_re, rf_we, busy;
  logic [7:0] rf_addr;
  logic [15:0] rf_wdata, rdq;

  fieldwr_seq #(.DEPTH(32), .TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ptr_we(ptr_we), .ptr_idx(ptr_idx),
    .place_we(place_we), .place_addr(place_addr), .place_lsb(place_lsb),
    .place_wcode(place_wcode), .act_we(act_we), .act_data(act_data),
    .act_delay(act_delay), .act_last(act_last), .go_we(go_we), .go_idx(go_idx),
    .abort(abort), .rf_re(rf_re), .rf_addr(rf_addr), .rf_rdata(rdq),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file model and write log
  logic [15:0] rmem [256];
  int wa [1024], wd [1024], wt [1024];
  int wn = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) rmem[a] <= 16'(a * 16'h0123) ^ 16'hA5C3;
      rdq <= '0;
    end else begin
      if (rf_re) rdq <= rmem[rf_addr];
      if (rf_we) begin
        rmem[rf_addr] <= rf_wdata;
        if (wn < 1024) begin wa[wn] <= int'(rf_addr); wd[wn] <= int'(rf_wdata); wt[wn] <= cyc; end
        wn <= wn + 1;
      end
    end
  end

  // bench copy of the step store
  int e_addr [32], e_lsb [32], e_wc [32], e_dat [32], e_dly [32], e_last [32];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_field(input int old, input int s, input int wc, input int d);
    int w, m, v;
    w = wc + 1;
    m = (((1 << w) - 1) << s) & 32'hFFFF;
    v = ((d & ((1 << w) - 1)) << s) & m;
    return (old & ~m & 32'hFFFF) | v;
  endfunction

  task automatic set_entry(input int i, input int a, input int s, input int wc,
                           input int d, input int dl, input int last);
    e_addr[i] = a; e_lsb[i] = s; e_wc[i] = wc; e_dat[i] = d; e_dly[i] = dl; e_last[i] = last;
  endtask

  // R2: program through pointer and the two halves
  task automatic prog(input int i, input int a, input int s, input int wc,
                      input int d, input int dl, input int last);
    @(negedge clk); ptr_we = 1; ptr_idx = 5'(i);
    @(negedge clk); ptr_we = 0; place_we = 1;
    place_addr = 8'(a); place_lsb = 4'(s); place_wcode = 3'(wc);
    @(negedge clk); place_we = 0; act_we = 1;
    act_data = 8'(d); act_delay = 4'(dl); act_last = last[0];
    @(negedge clk); act_we = 0;
    set_entry(i, a, s, wc, d, dl, last);
  endtask

  task automatic run_seq(input int idx, input string tag, input int inj);
    int ea [40], ev [40], ecyc [40], sh [256];
    int k, i, base, sum, t0, t1, n;
    for (int a = 0; a < 256; a++) sh[a] = int'(rmem[a]);
    i = idx; k = 0; sum = 0;
    while (k < 40) begin
      ea[k] = e_addr[i];
      sh[ea[k]] = exp_field(sh[ea[k]], e_lsb[i], e_wc[i], e_dat[i]);
      ev[k] = sh[ea[k]];
      ecyc[k] = TICK * ((1 << e_dly[i]) + 8);
      sum += ecyc[k];
      k++;
      if (e_last[i] != 0) break;
      i = (i + 1) % 32;
    end
    base = wn;
    @(negedge clk); go_we = 1; go_idx = 5'(idx);
    @(negedge clk); go_we = 0; t0 = cyc;
    check(busy == 1'b1, "R4 busy after start", int'(busy), 1);
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk); n++;
      if (n == inj) begin go_we = 1; go_idx = 5'd0; end else go_we = 0;
    end
    go_we = 0;
    t1 = cyc;
    check(t1 - t0 == sum, "R5 total busy time", t1 - t0, sum);
    check(wn - base == k, {tag, " R4 write count"}, wn - base, k);
    for (int j = 0; j < k && j < 40; j++) begin
      check(wa[base+j] == ea[j], "R11 write address", wa[base+j], ea[j]);
      check(wd[base+j] == ev[j], {tag, " R3 merged value"}, wd[base+j], ev[j]);
      if (j > 0)
        check(wt[base+j] - wt[base+j-1] == ecyc[j-1], "R5 step spacing",
              wt[base+j] - wt[base+j-1], ecyc[j-1]);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) set_entry(i, 0, 0, 0, 0, 0, 0);
    set_entry(0, 8'h01, 0, 2, 8'h05, 0, 0);
    set_entry(1, 8'h02, 4, 3, 8'h0A, 1, 0);
    set_entry(2, 8'h03, 8, 7, 8'h3C, 0, 1);
    set_entry(16, 8'h02, 4, 3, 8'h00, 0, 0);
    set_entry(17, 8'h01, 0, 2, 8'h00, 0, 1);
    void'($urandom(32'h5EC0_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(rf_we == 1'b0 && rf_re == 1'b0, "R1 strobes after reset", int'({rf_re, rf_we}), 0);
    en = 1;
    // R1 default lists
    run_seq(0, "R1 power-up", -1);
    run_seq(16, "R1 power-down", -1);
    // R10 field above bit 15
    prog(4, 8'h30, 12, 7, 8'hFF, 0, 1);
    run_seq(4, "R10 top field", -1);
    check(rmem[8'h30][15:12] == 4'hF, "R10 top nibble", int'(rmem[8'h30]), 16'hF000);
    // R3 extra data bits ignored
    prog(5, 8'h31, 2, 2, 8'hFD, 0, 1);
    run_seq(5, "R3 narrow field", -1);
    // R5 longer delay
    prog(6, 8'h32, 0, 7, 8'h81, 5, 0);
    prog(7, 8'h33, 3, 0, 8'h01, 0, 1);
    run_seq(6, "R5 delay mix", -1);
    // R9 wrap 31 -> 0
    prog(30, 8'h40, 1, 1, 8'h02, 0, 0);
    prog(31, 8'h41, 5, 4, 8'h13, 1, 0);
    prog(0, 8'h42, 0, 3, 8'h09, 0, 1);
    run_seq(30, "R9 wrap", -1);
    // R8 start while busy is ignored
    prog(8, 8'h50, 0, 7, 8'h11, 3, 0);
    prog(9, 8'h51, 4, 3, 8'h07, 3, 0);
    prog(10, 8'h52, 8, 5, 8'h2A, 3, 1);
    run_seq(8, "R8 go while busy", 5);
    begin
      int base;
      // R6 abort after the first write
      base = wn;
      @(negedge clk); go_we = 1; go_idx = 5'd8;
      @(negedge clk); go_we = 0;
      for (int g = 0; g < 500 && wn == base; g++) @(negedge clk);
      abort = 1; @(negedge clk); abort = 0;
      check(busy == 1'b0, "R6 busy after abort", int'(busy), 0);
      repeat (120) @(negedge clk);
      check(wn - base == 1, "R6 writes after abort", wn - base, 1);
      // R7 enable drop mid-run
      base = wn;
      @(negedge clk); go_we = 1; go_idx = 5'd8;
      @(negedge clk); go_we = 0;
      for (int g = 0; g < 500 && wn == base; g++) @(negedge clk);
      en = 0; @(negedge clk);
      check(busy == 1'b0, "R7 busy after enable drop", int'(busy), 0);
      repeat (120) @(negedge clk);
      check(wn - base == 1, "R7 writes after enable drop", wn - base, 1);
      // R7 start with enable low
      base = wn;
      @(negedge clk); go_we = 1; go_idx = 5'd8;
      @(negedge clk); go_we = 0;
      check(busy == 1'b0, "R7 start while disabled", int'(busy), 0);
      repeat (80) @(negedge clk);
      check(wn - base == 0, "R7 no writes while disabled", wn - base, 0);
      en = 1;
    end
    // R3 random lists
    for (int it = 0; it < 12; it++) begin
      int b, len;
      b = 11 + int'($urandom % 4);
      len = 1 + int'($urandom % 4);
      for (int j = 0; j < len; j++)
        prog(b + j, 8'h20 + int'($urandom % 8), int'($urandom % 16), int'($urandom % 8),
             int'($urandom % 256), int'($urandom % 3), (j == len - 1) ? 1 : 0);
      run_seq(b, "R3 random", -1);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule